// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clock domains of a small controller run. It drives five registered enables: the CPU/main clock, the sub-main peripheral clock and the auxiliary clock. It also enables the digitally controlled oscillator's DC generator and the crystal oscillator. A CPU-run output tells the core whether it may fetch instructions. Software selects one of six modes: an active mode and five progressively deeper low-power modes. It does this by writing a 3-bit mode code.

An interrupt request in any low-power mode forces the block back to active mode, so that the handler can run. The low-power mode that was left is remembered. A return-from-interrupt pulse then puts that mode back. A handler may itself enter a low-power mode and be woken again. In that case the first (outermost) saved mode is the one that is restored.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in active mode (code 0), and all six outputs are 1.
- R2: A write of code 0..5 selects that mode. The outputs show the new mode's pattern one clock edge after the write is sampled. Output bit order here is {cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en}, and code 0 (active) gives 111111.
- R3: Code 1 (light sleep) gives 001111: CPU and main clock off, sub-main and auxiliary clocks running.
- R4: Code 2 (light sleep with generator option) gives 0011d1. Here d is the current value of dco_active_use: the DC generator stays on only when the oscillator is used in active mode.
- R5: Code 3 gives 000111: main and sub-main clocks off, while the DC generator and the auxiliary clock stay on.
- R6: Code 4 gives 000101: only the auxiliary clock (and crystal) run, and the DC generator is off.
- R7: Code 5 (deepest) gives 000000: every clock, the DC generator and the crystal oscillator are off.
- R8: Writes of code 6 or 7 are ignored, and the mode and outputs stay as they were.
- R9: An interrupt request in a low-power mode returns the block to active mode on the next edge. A later return pulse restores the mode that was left.
- R10: An interrupt in active mode, with nothing saved, saves nothing. A return pulse with nothing saved leaves the mode unchanged.
- R11: When a handler enters a low-power mode and is woken again, the first saved mode is kept. The next return restores that outermost mode.
- R12: Priority is interrupt, then return, then write. If a valid write and an interrupt come in the same cycle, the written mode is saved and the block goes active. If an interrupt and a return come together, the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode-code write strobe |
| mode_code | input | 3 | Requested mode code, 0..5 valid |
| dco_active_use | input | 1 | Oscillator is used in active mode |
| wake_irq | input | 1 | Interrupt request pending |
| irq_return | input | 1 | Return-from-interrupt pulse |
| cpu_run | output | 1 | CPU may execute |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | Oscillator DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The mode write and the interrupt wake-up can fall in the same cycle. So can the wake-up and the interrupt return. The bench drives a sleep write together with an interrupt on one edge, and an interrupt together with a return on another. It then checks that the block goes active, and that the later return restores the written mode, or the mode saved before. Its own mode model predicts each output pattern, and a scoreboard queue compares that prediction one edge later.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int MODE_W   = 3;
  localparam int MODE_MAX = 5;

  typedef enum logic [MODE_W-1:0] {
    PM_ACT = 3'd0,
    PM_LP0 = 3'd1,
    PM_LP1 = 3'd2,
    PM_LP2 = 3'd3,
    PM_LP3 = 3'd4,
    PM_LP4 = 3'd5
  } pm_mode_t;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic smclk;
    logic aclk;
    logic dcgen;
    logic xtal;
  } gate_t;

  localparam gate_t GATE_ALL_ON = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1,
                                    aclk: 1'b1, dcgen: 1'b1, xtal: 1'b1};

  function automatic logic code_ok(input logic [MODE_W-1:0] c);
    return (int'(c) <= MODE_MAX);
  endfunction

  // Gating pattern of one mode; dco_used only matters in PM_LP1.
  function automatic gate_t gate_of(input pm_mode_t m, input logic dco_used);
    gate_t g;
    g = GATE_ALL_ON;
    case (m)
      PM_ACT: g = GATE_ALL_ON;
      PM_LP0: begin g.cpu = 1'b0; g.mclk = 1'b0; end
      PM_LP1: begin g.cpu = 1'b0; g.mclk = 1'b0; g.dcgen = dco_used; end
      PM_LP2: begin g.cpu = 1'b0; g.mclk = 1'b0; g.smclk = 1'b0; end
      PM_LP3: begin g.cpu = 1'b0; g.mclk = 1'b0; g.smclk = 1'b0; g.dcgen = 1'b0; end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pmc_mode_seq.sv
module pmc_mode_seq
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              irq_req,
  input  logic              irq_ret,
  output pm_mode_t          mode_nxt
);

  pm_mode_t cur_q, saved_q, eff_mode;
  logic     saved_vld_q;

  // Named internal events for the assertions
  logic wr_accept, wake_evt, capture_evt, restore_evt;

  assign wr_accept   = mode_wr && code_ok(mode_code);
  assign eff_mode    = wr_accept ? pm_mode_t'(mode_code) : cur_q;
  assign wake_evt    = irq_req;
  assign capture_evt = wake_evt && (eff_mode != PM_ACT) && !saved_vld_q;
  assign restore_evt = !wake_evt && irq_ret && saved_vld_q;

  always_comb begin
    if (wake_evt)         mode_nxt = PM_ACT;
    else if (restore_evt) mode_nxt = saved_q;
    else                  mode_nxt = eff_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= PM_ACT;
      saved_q     <= PM_ACT;
      saved_vld_q <= 1'b0;
    end else begin
      cur_q <= mode_nxt;
      if (capture_evt) begin
        saved_q     <= eff_mode;
        saved_vld_q <= 1'b1;
      end else if (restore_evt) begin
        saved_vld_q <= 1'b0;
      end
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !irq_req && !irq_ret) |=> (cur_q == pm_mode_t'($past(mode_code))));

  a_r8_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !code_ok(mode_code) && !irq_req && !irq_ret) |=> $stable(cur_q));

  a_r11_outer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (saved_vld_q && !restore_evt) |=> (saved_vld_q && $stable(saved_q)));

  a_r10_no_save_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!saved_vld_q && irq_req && !mode_wr && cur_q == PM_ACT) |=> !saved_vld_q);

endmodule

// File: rtl/pmc_gate_reg.sv
module pmc_gate_reg
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_t mode_nxt,
  input  logic     dco_used,
  output gate_t    gate_q
);

  gate_t gate_d;
  assign gate_d = gate_of(mode_nxt, dco_used);

  // Every enable is a flop output: no glitch reaches the clock gates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATE_ALL_ON;
    else        gate_q <= gate_d;
  end

  a_r4_dco_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_nxt == PM_LP1) |=> (gate_q.dcgen == $past(dco_used)));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              dco_active_use,
  input  logic              wake_irq,
  input  logic              irq_return,
  output logic              cpu_run,
  output logic              mclk_en,
  output logic              smclk_en,
  output logic              aclk_en,
  output logic              dcgen_en,
  output logic              xtal_en
);

  pm_mode_t mode_nxt;
  gate_t    gate_q;

  pmc_mode_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_code (mode_code),
    .irq_req   (wake_irq),
    .irq_ret   (irq_return),
    .mode_nxt  (mode_nxt)
  );

  pmc_gate_reg u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_nxt (mode_nxt),
    .dco_used (dco_active_use),
    .gate_q   (gate_q)
  );

  assign cpu_run  = gate_q.cpu;
  assign mclk_en  = gate_q.mclk;
  assign smclk_en = gate_q.smclk;
  assign aclk_en  = gate_q.aclk;
  assign dcgen_en = gate_q.dcgen;
  assign xtal_en  = gate_q.xtal;

  a_r9_wake_runs_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> (cpu_run && mclk_en));

  a_r3_clock_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |-> (smclk_en && aclk_en));

  a_r7_xtal_last: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |-> (!aclk_en && !dcgen_en && !smclk_en));

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [2:0] mode_code;
  logic       dco_active_use;
  logic       wake_irq;
  logic       irq_return;
  logic       cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en;

  int n_checks = 0;
  int n_fails  = 0;

  logic [5:0] q_exp[$];
  string      q_tag[$];

  int m_mode  = 0;
  int m_saved = 0;
  bit m_sv_v  = 0;
  bit driver_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_wr        (mode_wr),
    .mode_code      (mode_code),
    .dco_active_use (dco_active_use),
    .wake_irq       (wake_irq),
    .irq_return     (irq_return),
    .cpu_run        (cpu_run),
    .mclk_en        (mclk_en),
    .smclk_en       (smclk_en),
    .aclk_en        (aclk_en),
    .dcgen_en       (dcgen_en),
    .xtal_en        (xtal_en)
  );

  // Expected pattern {cpu, mclk, smclk, aclk, dcgen, xtal} per code
  function automatic logic [5:0] expect_bits(input int mode, input logic dco);
    logic cpu, sm, ac, dc, xt;
    cpu = (mode == 0);
    sm  = (mode < 3);
    ac  = (mode < 5);
    dc  = (mode == 0) || (mode == 1) || (mode == 3) || ((mode == 2) && dco);
    xt  = (mode != 5);
    return {cpu, cpu, sm, ac, dc, xt};
  endfunction

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic step(input logic wr, input logic [2:0] code, input logic irq,
                      input logic ret, input logic dco, input string tag);
    int eff;
    @(negedge clk);
    mode_wr        = wr;
    mode_code      = code;
    wake_irq       = irq;
    irq_return     = ret;
    dco_active_use = dco;
    eff = (wr && code < 3'd6) ? int'(code) : m_mode;
    if (irq) begin
      if (eff != 0 && !m_sv_v) begin
        m_saved = eff;
        m_sv_v  = 1;
      end
      m_mode = 0;
    end else if (ret && m_sv_v) begin
      m_mode = m_saved;
      m_sv_v = 0;
    end else begin
      m_mode = eff;
    end
    q_exp.push_back(expect_bits(m_mode, dco));
    q_tag.push_back(tag);
  endtask

  // Monitor: pops one expectation per edge, sampled a quarter period later
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_exp.size() > 0) begin
        logic [5:0] exp_v, act_v;
        string      t;
        exp_v = q_exp.pop_front();
        t     = q_tag.pop_front();
        act_v = {cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en};
        n_checks++;
        if (act_v !== exp_v) begin
          n_fails++;
          $display("FAIL %s actual=%b expected=%b", t, act_v, exp_v);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_wr = 0; mode_code = 0; wake_irq = 0;
    irq_return = 0; dco_active_use = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    n_checks++;
    if ({cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en} !== 6'b111111) begin
      n_fails++;
      $display("FAIL R1 in reset actual=%b expected=111111",
               {cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en});
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 0, 0, 0, 0, "R1 after release");
    step(1, 0, 0, 0, 0, "R2 write active");
    step(1, 1, 0, 0, 0, "R3 light sleep");
    step(0, 0, 0, 0, 0, "R3 hold");
    step(1, 2, 0, 0, 0, "R4 gen off without dco use");
    step(0, 0, 0, 0, 1, "R4 gen on with dco use");
    step(1, 3, 0, 0, 1, "R5 code 3");
    step(1, 4, 0, 0, 1, "R6 code 4");
    step(1, 5, 0, 0, 1, "R7 deepest");
    step(1, 6, 0, 0, 1, "R8 code 6 ignored");
    step(1, 7, 0, 0, 1, "R8 code 7 ignored");
    step(0, 0, 1, 0, 1, "R9 wake from deepest");
    step(0, 0, 0, 0, 1, "R9 servicing");
    step(0, 0, 0, 1, 1, "R9 restore deepest");
    step(1, 0, 0, 0, 0, "R2 back to active");
    step(0, 0, 1, 0, 0, "R10 irq in active");
    step(0, 0, 0, 1, 0, "R10 return with nothing saved");
    step(1, 4, 0, 0, 0, "R6 enter code 4");
    step(0, 0, 1, 0, 0, "R11 first wake");
    step(1, 2, 0, 0, 0, "R11 handler sleeps");
    step(0, 0, 1, 0, 0, "R11 nested wake");
    step(0, 0, 0, 1, 0, "R11 restore outermost");
    step(1, 0, 0, 0, 0, "R2 active again");
    step(1, 3, 1, 0, 0, "R12 write and irq same cycle");
    step(0, 0, 0, 1, 0, "R12 restore written mode");
    step(0, 0, 1, 1, 0, "R12 irq beats return");
    step(0, 0, 0, 1, 0, "R12 later return restores");
    step(1, 1, 0, 1, 0, "R12 return with nothing saved lets write land");
    step(0, 0, 0, 0, 0, "R3 idle");
    driver_done = 1;

    wait (q_exp.size() == 0);
    @(negedge clk);
    summary();
    $finish;
  end

endmodule